// File: doc/BRIEF.md
# Polarity-Selectable Phase Detector with Lock Indicator

This block compares two single-cycle-domain pulse streams: one from the RF-path divider and one from the reference divider. It turns the timing gap between their rising edges into up and down pump commands for an external charge pump. It uses a two-flip-flop phase-frequency detector, so it also pulls the loop toward the right frequency.

A register bit sets the sign of the commands, so the block can drive loop filters of either sense. Configuration words arrive on a 16-bit bus, and an address select routes each word to one of two groups. While the load strobe is high, words are captured and the whole detector is held idle. When the strobe falls, the new settings take effect.

A digital lock detector watches each comparison. It counts how many consecutive comparisons stay within a programmed width threshold. Once the count reaches a programmed filter length, it raises a lock flag and enables an external lock-indicator sink. The RF-group word also carries a 2-bit gain code, which is brought out for scaling the external pump current.

Top module: `pdl_phase_lock`

## Requirements
- R1: A word on `cfg_data` is captured while `load_strobe` is high. It goes to the RF group when `grp_sel`=1 and to the reference group when `grp_sel`=0. In the RF word, bits [1:0] are the gain code. In the reference word, bits [3:0] are the width threshold, bits [11:4] are the lock length N, and bit 12 is the polarity. New settings take effect on the first clock edge after the strobe falls. Until then, `gain_code` keeps its previous value. All settings reset to zero.
- R2: A rising edge on `rf_pulse` sets the lead state, and a rising edge on `ref_pulse` sets the lag state. In the cycle after both are set, both clear. If the second edge arrives d cycles after the first, the output for the earlier input is high for d+1 cycles and the other output is high for 1 cycle. Edges in the same cycle give 1 cycle on both outputs.
- R3: With polarity=1, the RF-leading state drives `pump_down` and the reference-leading state drives `pump_up`. With polarity=0, the mapping is swapped.
- R4: While `load_strobe` is high, both pump outputs are low and the detector state is cleared. An input that is already high when the strobe falls produces no comparison.
- R5: Each comparison measures d, the number of cycles between the two edges. The comparison is good when d is at most the threshold.
- R6: `lock_flag` rises after N consecutive good comparisons, with N=0 treated as 1. It changes in the cycle in which the completing comparison clears the detector.
- R7: A single comparison that is not good clears `lock_flag` and the run count.
- R8: A high `load_strobe` clears `lock_flag` and the run count.
- R9: `lock_sink_en` is high exactly when `lock_flag` is high and `load_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data | input | 16 | Configuration word |
| grp_sel | input | 1 | 1 selects the RF group, 0 selects the reference group |
| load_strobe | input | 1 | High: capture the word and hold the detector idle |
| rf_pulse | input | 1 | RF-path divider pulse |
| ref_pulse | input | 1 | Reference divider pulse |
| pump_up | output | 1 | Up (source) pump command |
| pump_down | output | 1 | Down (sink) pump command |
| lock_flag | output | 1 | Loop judged locked |
| lock_sink_en | output | 1 | Enable for the external lock-indicator sink |
| gain_code | output | 2 | Gain field for external current scaling |

## Verification
The assertions check the following on every cycle:
- a pair of set detector states always clears one cycle later;
- both pumps never overlap for more than one cycle;
- the strobe empties the detector and drops lock;
- lock never survives a failing comparison and only rises after a passing one;
- the sink enable is never on without lock.

Only the bench scenarios can show the rest: the exact pulse widths for leads of either sign, the polarity swap, lock arriving on exactly the N-th good comparison (including N=0), and the gain code holding its old value until the strobe falls.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  // Rising-edge detect from the current and previous sample.
  function automatic logic f_rise(logic cur, logic prev);
    return cur & ~prev;
  endfunction

  // A comparison is good when its measured width is within the threshold.
  function automatic logic f_within(int unsigned width, int unsigned thr);
    return width <= thr;
  endfunction

  // A lock length of zero behaves as one.
  function automatic int unsigned f_target(int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  // Map the lead/lag state onto {up, down} by polarity.
  function automatic logic [1:0] f_map(logic lead, logic lag, logic pol);
    return pol ? {lag, lead} : {lead, lag};
  endfunction

endpackage

// File: rtl/pdl_cfg_regs.sv
module pdl_cfg_regs #(
  parameter int DATA_W  = 16,
  parameter int GAIN_W  = 2,
  parameter int THR_W   = 4,
  parameter int CNT_W   = 8,
  parameter int POL_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              grp_sel,
  input  logic              load_strobe,
  output logic [GAIN_W-1:0] gain_q,
  output logic [THR_W-1:0]  thr_q,
  output logic [CNT_W-1:0]  len_q,
  output logic              pol_q
);
  localparam int LEN_LSB = THR_W;

  logic [DATA_W-1:0] rf_buf;
  logic [DATA_W-1:0] ref_buf;

  // Capture buffers: follow the bus while the strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_buf  <= '0;
      ref_buf <= '0;
    end else if (load_strobe) begin
      if (grp_sel) rf_buf  <= cfg_data;
      else         ref_buf <= cfg_data;
    end
  end

  // Active settings: copied from the buffers while the strobe is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      thr_q  <= '0;
      len_q  <= '0;
      pol_q  <= 1'b0;
    end else if (!load_strobe) begin
      gain_q <= rf_buf[GAIN_W-1:0];
      thr_q  <= ref_buf[THR_W-1:0];
      len_q  <= ref_buf[LEN_LSB +: CNT_W];
      pol_q  <= ref_buf[POL_BIT];
    end
  end
endmodule

// File: rtl/pdl_pfd_core.sv
module pdl_pfd_core #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             rf_in,
  input  logic             ref_in,
  input  logic             pol,
  output logic             pump_up,
  output logic             pump_down,
  output logic             lead_q,
  output logic             lag_q,
  output logic             cmp_event,
  output logic [WID_W-1:0] width_q
);
  import pdl_pkg::*;

  localparam logic [WID_W-1:0] WID_MAX = '1;

  logic       rf_prev;
  logic       ref_prev;
  logic       rf_rise;
  logic       ref_rise;
  logic [1:0] mapped;

  assign rf_rise   = f_rise(rf_in, rf_prev);
  assign ref_rise  = f_rise(ref_in, ref_prev);
  assign cmp_event = lead_q & lag_q & ~hold;
  assign mapped    = f_map(lead_q, lag_q, pol);
  assign pump_up   = mapped[1] & ~hold;
  assign pump_down = mapped[0] & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_prev  <= 1'b0;
      ref_prev <= 1'b0;
      lead_q   <= 1'b0;
      lag_q    <= 1'b0;
      width_q  <= '0;
    end else begin
      rf_prev  <= rf_in;
      ref_prev <= ref_in;
      if (hold || (lead_q && lag_q)) begin
        lead_q  <= 1'b0;
        lag_q   <= 1'b0;
        width_q <= '0;
      end else begin
        lead_q <= lead_q | rf_rise;
        lag_q  <= lag_q | ref_rise;
        if ((lead_q ^ lag_q) && (width_q != WID_MAX))
          width_q <= width_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdl_lock_det.sv
module pdl_lock_det #(
  parameter int THR_W = 4,
  parameter int CNT_W = 8,
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             cmp_event,
  input  logic [WID_W-1:0] width,
  input  logic [THR_W-1:0] thr,
  input  logic [CNT_W-1:0] len,
  output logic             cmp_good,
  output logic             lock_flag
);
  import pdl_pkg::*;

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_nxt;
  int unsigned      target;

  assign cmp_good = f_within(32'(width), 32'(thr));
  assign target   = f_target(32'(len));

  always_comb begin
    run_nxt = run_q;
    if (32'(run_q) < target) run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= '0;
      lock_flag <= 1'b0;
    end else if (hold) begin
      run_q     <= '0;
      lock_flag <= 1'b0;
    end else if (cmp_event) begin
      if (cmp_good) begin
        run_q     <= run_nxt;
        lock_flag <= (32'(run_nxt) >= target);
      end else begin
        run_q     <= '0;
        lock_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pdl_phase_lock.sv
module pdl_phase_lock #(
  parameter int DATA_W  = 16,
  parameter int GAIN_W  = 2,
  parameter int THR_W   = 4,
  parameter int CNT_W   = 8,
  parameter int WID_W   = 8,
  parameter int POL_BIT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              grp_sel,
  input  logic              load_strobe,
  input  logic              rf_pulse,
  input  logic              ref_pulse,
  output logic              pump_up,
  output logic              pump_down,
  output logic              lock_flag,
  output logic              lock_sink_en,
  output logic [GAIN_W-1:0] gain_code
);
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] len_q;
  logic             pol_q;
  logic             lead_q;
  logic             lag_q;
  logic             cmp_event;
  logic             cmp_good;
  logic [WID_W-1:0] width_q;

  pdl_cfg_regs #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .THR_W(THR_W),
    .CNT_W(CNT_W), .POL_BIT(POL_BIT)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .grp_sel(grp_sel),
    .load_strobe(load_strobe), .gain_q(gain_code), .thr_q(thr_q),
    .len_q(len_q), .pol_q(pol_q)
  );

  pdl_pfd_core #(.WID_W(WID_W)) u_pfd (
    .clk(clk), .rst_n(rst_n), .hold(load_strobe), .rf_in(rf_pulse),
    .ref_in(ref_pulse), .pol(pol_q), .pump_up(pump_up),
    .pump_down(pump_down), .lead_q(lead_q), .lag_q(lag_q),
    .cmp_event(cmp_event), .width_q(width_q)
  );

  pdl_lock_det #(.THR_W(THR_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .hold(load_strobe), .cmp_event(cmp_event),
    .width(width_q), .thr(thr_q), .len(len_q), .cmp_good(cmp_good),
    .lock_flag(lock_flag)
  );

  assign lock_sink_en = lock_flag & ~load_strobe;
endmodule

// File: rtl/pdl_phase_lock_chk.sv
module pdl_phase_lock_chk (
  input logic clk,
  input logic rst_n,
  input logic load_strobe,
  input logic pump_up,
  input logic pump_down,
  input logic lead_q,
  input logic lag_q,
  input logic cmp_event,
  input logic cmp_good,
  input logic lock_flag,
  input logic lock_sink_en
);
  AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q && lag_q |=> !(lead_q && lag_q)); // R2
  AST_NO_LONG_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    pump_up && pump_down |=> !(pump_up && pump_down)); // R2
  AST_HOLD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !lead_q && !lag_q); // R4
  AST_BAD_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event && !cmp_good |=> !lock_flag); // R7
  AST_LOCK_FROM_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_flag) |-> $past(cmp_event && cmp_good)); // R6
  AST_HOLD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !lock_flag); // R8
  AST_SINK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_flag |-> !lock_sink_en); // R9
endmodule

bind pdl_phase_lock pdl_phase_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_strobe(load_strobe), .pump_up(pump_up),
  .pump_down(pump_down), .lead_q(lead_q), .lag_q(lag_q),
  .cmp_event(cmp_event), .cmp_good(cmp_good), .lock_flag(lock_flag),
  .lock_sink_en(lock_sink_en)
);

// File: tb/tb_pdl_phase_lock.sv
module tb_pdl_phase_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_data = '0;
  logic        grp_sel = 1'b0;
  logic        load_strobe = 1'b0;
  logic        rf_pulse = 1'b0;
  logic        ref_pulse = 1'b0;
  logic        pump_up, pump_down, lock_flag, lock_sink_en;
  logic [1:0]  gain_code;

  pdl_phase_lock dut (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .grp_sel(grp_sel),
    .load_strobe(load_strobe), .rf_pulse(rf_pulse), .ref_pulse(ref_pulse),
    .pump_up(pump_up), .pump_down(pump_down), .lock_flag(lock_flag),
    .lock_sink_en(lock_sink_en), .gain_code(gain_code)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_up_q[$];
  int exp_dn_q[$];
  string exp_tag_q[$];
  int events = 0;

  // Bench lock model
  int m_thr = 0, m_len = 0, m_run = 0, m_pol = 0;
  bit m_lock = 0;

  task automatic check(bit ok, string rq, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Monitor: measures pump widths per comparison and pops the scoreboard.
  int up_acc = 0, dn_acc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pump_up || pump_down) begin
        if (pump_up) up_acc++;
        if (pump_down) dn_acc++;
      end else if (up_acc != 0 || dn_acc != 0) begin
        events++;
        if (exp_up_q.size() == 0) begin
          check(0, "R4 unexpected pump activity", up_acc + dn_acc, 0);
        end else begin
          int eu, ed;
          string t;
          eu = exp_up_q.pop_front();
          ed = exp_dn_q.pop_front();
          t  = exp_tag_q.pop_front();
          check(up_acc == eu, {t, " pump_up width"}, up_acc, eu);
          check(dn_acc == ed, {t, " pump_down width"}, dn_acc, ed);
        end
        up_acc = 0;
        dn_acc = 0;
      end
    end
  end

  task automatic write_cfg(bit rf_grp, logic [15:0] w);
    @(negedge clk);
    grp_sel = rf_grp; cfg_data = w; load_strobe = 1'b1;
    @(negedge clk);
    check(lock_flag == 1'b0, "R8 lock cleared by strobe", lock_flag, 0);
    check(pump_up == 1'b0 && pump_down == 1'b0, "R4 pumps idle on strobe",
          {pump_up, pump_down}, 0);
    load_strobe = 1'b0;
    @(negedge clk);
    m_run = 0; m_lock = 0;
    if (!rf_grp) begin
      m_thr = int'(w[3:0]); m_len = int'(w[11:4]); m_pol = int'(w[12]);
    end
  endtask

  function automatic logic [15:0] ref_word(int pol, int len, int thr);
    logic [15:0] w;
    w = '0;
    w[12] = pol[0];
    w[11:4] = len[7:0];
    w[3:0] = thr[3:0];
    return w;
  endfunction

  // Driver: d>0 RF leads by d cycles, d<0 reference leads, 0 simultaneous.
  task automatic do_cmp(int d, string tag, string lock_tag);
    int rf_w, ref_w, ad, tgt;
    ad    = (d < 0) ? -d : d;
    rf_w  = (d > 0) ? d + 1 : 1;
    ref_w = (d < 0) ? ad + 1 : 1;
    if (m_pol != 0) begin
      exp_up_q.push_back(ref_w); exp_dn_q.push_back(rf_w);
    end else begin
      exp_up_q.push_back(rf_w);  exp_dn_q.push_back(ref_w);
    end
    exp_tag_q.push_back(tag);
    @(negedge clk);
    if (d >= 0) rf_pulse = 1'b1;
    if (d <= 0) ref_pulse = 1'b1;
    repeat (ad) @(negedge clk);
    rf_pulse = 1'b1; ref_pulse = 1'b1;
    repeat (2) @(negedge clk);
    rf_pulse = 1'b0; ref_pulse = 1'b0;
    repeat (4) @(negedge clk);
    tgt = (m_len == 0) ? 1 : m_len;
    if (ad <= m_thr) begin
      if (m_run < tgt) m_run++;
      m_lock = (m_run >= tgt);
    end else begin
      m_run = 0; m_lock = 0;
    end
    check(lock_flag == m_lock, lock_tag, lock_flag, m_lock);
    check(lock_sink_en == m_lock, "R9 sink enable", lock_sink_en, m_lock);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pump_up == 0 && pump_down == 0, "R2 reset pumps", {pump_up, pump_down}, 0);
    check(lock_flag == 0, "R6 reset lock", lock_flag, 0);
    check(gain_code == 2'd0, "R1 reset gain", gain_code, 0);

    // R1: gain held while strobe high, applied after it falls
    @(negedge clk);
    grp_sel = 1'b1; cfg_data = 16'h0002; load_strobe = 1'b1;
    repeat (2) @(negedge clk);
    check(gain_code == 2'd0, "R1 gain held during strobe", gain_code, 0);
    load_strobe = 1'b0;
    @(negedge clk);
    check(gain_code == 2'd2, "R1 gain applied", gain_code, 2);

    // Polarity 1, threshold 2, length 3
    write_cfg(1'b0, ref_word(1, 3, 2));
    check(gain_code == 2'd2, "R1 gain unaffected by ref word", gain_code, 2);
    do_cmp(1,  "R3 R2 pol1 rf lead 1", "R6 no lock after 1 good");
    do_cmp(-2, "R3 R2 pol1 ref lead 2", "R6 no lock after 2 good");
    do_cmp(0,  "R2 simultaneous", "R6 lock after 3 good");
    do_cmp(3,  "R2 R5 rf lead 3", "R7 bad comparison drops lock");
    do_cmp(2,  "R5 rf lead 2", "R6 R5 at threshold counts good");
    do_cmp(1,  "R2 rf lead 1", "R6 relock pending");
    do_cmp(-1, "R2 ref lead 1", "R6 relock");

    // Rewrite drops lock (R8) and flips polarity (R3)
    write_cfg(1'b0, ref_word(0, 3, 2));
    check(lock_flag == 0, "R8 lock gone after rewrite", lock_flag, 0);
    do_cmp(2,  "R3 pol0 rf lead 2", "R6 pol0 count 1");
    do_cmp(-1, "R3 pol0 ref lead 1", "R6 pol0 count 2");

    // R4: edges during the strobe and levels held across its fall are ignored
    begin
      int ev0;
      ev0 = events;
      @(negedge clk);
      grp_sel = 1'b1; cfg_data = 16'h0002; load_strobe = 1'b1; rf_pulse = 1'b1;
      @(negedge clk);
      check(pump_up == 0 && pump_down == 0, "R4 rf edge under strobe", {pump_up, pump_down}, 0);
      ref_pulse = 1'b1;
      @(negedge clk);
      load_strobe = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check(pump_up == 0 && pump_down == 0, "R4 held levels after strobe",
              {pump_up, pump_down}, 0);
      end
      rf_pulse = 1'b0; ref_pulse = 1'b0;
      repeat (3) @(negedge clk);
      check(events == ev0, "R4 no comparison from strobed edges", events, ev0);
      m_run = 0; m_lock = 0;
    end

    // Length 0 behaves as 1; threshold 1
    write_cfg(1'b0, ref_word(1, 0, 1));
    do_cmp(1, "R2 len0 rf lead 1", "R6 length zero locks at once");
    do_cmp(2, "R2 len0 rf lead 2", "R7 over threshold drops lock");
    do_cmp(-1, "R2 len0 ref lead 1", "R6 length zero relocks");

    repeat (4) @(negedge clk);
    check(exp_up_q.size() == 0, "R2 all comparisons observed", exp_up_q.size(), 0);
    summary();
  end
endmodule